// File: doc/BRIEF.md
# Interpolating Waveform Synthesizer

This block is a direct digital synthesizer for arbitrary waveforms. A phase register adds a programmable tuning word on every clock. The top bits of the phase select an entry in a full-cycle waveform table, and the table returns that entry and its right-hand neighbour in the same clock. A multiply-add stage then blends the two entries, with the phase bits just below the table address as the weight. The result is rounded to the converter width and comes out at one sample per clock.

The table has its own write port, so a host can load any shape one word per cycle while the synthesizer keeps running. Table samples are signed two's complement and two bits wider than the output, which leaves room for later scaling. A mode input turns the blend off, so the raw entry is passed through and step edges in a loaded shape stay sharp. The external reset goes through a synchronizer before it clears the phase and the pipeline.

Top module: `wave_synth`

## Requirements
- R1: After reset, out_valid goes high and stays high on every clock until the next reset. The sample for the phase value formed at rising edge n is on out_sample after edge n+3, so the latency is fixed at three cycles.
- R2: The phase register is PHASE_W bits wide. It adds tune on every rising edge, modulo 2^PHASE_W. A new tune value is used by the very next update.
- R3: Entry index k is phase[PHASE_W-1 -: ADDR_W]. The neighbour is k+1 modulo 2^ADDR_W, so the last entry blends toward entry 0.
- R4: The weight f is phase[PHASE_W-ADDR_W-1 -: FRAC_W], taken as unsigned. With signed entries a = table[k] and b = table[k+1], the full-precision value is s = a·2^FRAC_W + (b − a)·f.
- R5: The output is floor((s + 2^(SH−1)) / 2^SH), with SH = DATA_W − OUT_W + FRAC_W. It is saturated to the signed OUT_W range (8191 and −8192 with the defaults).
- R6: When interp_off is high, f is taken as 0, so the output depends on table[k] only. interp_off is paired with the phase update on the same edge as tune.
- R7: When wr_en is high at a rising edge, the table word at wr_addr takes wr_data. A read on any later edge returns the new word. Writes do not stall or disturb the output stream.
- R8: rst_n is synchronous and active low, and it passes through two flops. While reset is in effect, phase is 0, out_valid is 0 and out_sample is 0. The first accumulation happens on the third rising edge after rst_n is first sampled high. Reset does not clear the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronized inside |
| tune | input | PHASE_W | Phase increment per clock |
| interp_off | input | 1 | 1 = pass the raw entry with no blending |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | ADDR_W | Table write address |
| wr_data | input | DATA_W | Table write word, signed |
| out_valid | output | 1 | Output sample is valid |
| out_sample | output | OUT_W | Rounded, saturated signed sample |

## Verification
Each sample is due exactly three edges after the edge that formed its phase. The first accumulation is due two edges after the reset release is sampled, and out_valid follows after three more. The bench keeps its own phase and table model. At each edge it records the expected sample and the requirement it tests, and it compares out_sample against the entry recorded three steps earlier, sampling at the falling edge. A table write is applied to the model on the same edge as the hardware write, so a read on the next edge sees the new word in both.

// File: rtl/wsyn_pkg.sv
// Shared constants for the waveform synthesizer.
// Assumes: nothing; it holds only pipeline facts that several files agree on.
package wsyn_pkg;
    // Edges from the phase register update to the output register update.
    localparam int unsigned PIPE_LAT = 3;
    // Flop count in the reset synchronizer.
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/wsyn_rst_sync.sv
// Reset synchronizer: moves the external active-low reset into the clock
// domain through a chain of STAGES flops.
// Assumes: STAGES >= 1; the chain itself carries no reset.
module wsyn_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n_in,
    output logic rst_n_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop: capture the reset level.
            always_ff @(posedge clk) begin
                chain[0] <= rst_n_in;
            end
        end else begin : g_multi
            // Shift the reset level through the chain.
            always_ff @(posedge clk) begin
                chain <= {chain[STAGES-2:0], rst_n_in};
            end
        end
    endgenerate

    assign rst_n_sync = chain[STAGES-1];
endmodule

// File: rtl/wsyn_phase_acc.sv
// Phase register: adds the tuning word every clock and carries the
// bypass mode and a valid flag alongside the phase value.
// Assumes: rst_n is already synchronized; wrap-around modulo 2^PHASE_W.
module wsyn_phase_acc #(
    parameter int unsigned PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tune,
    input  logic               byp_in,
    output logic [PHASE_W-1:0] phase,
    output logic               byp,
    output logic               vld
);
    // Accumulate the phase and register the mode bit with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            byp   <= 1'b0;
            vld   <= 1'b0;
        end else begin
            phase <= phase + tune;
            byp   <= byp_in;
            vld   <= 1'b1;
        end
    end
endmodule

// File: rtl/wsyn_wave_ram.sv
// Waveform table: one write port and two registered read ports. The read
// ports return entry k and entry k+1 (modulo depth) in the same cycle.
// Assumes: read-before-write when a read and a write hit the same word on
// the same edge; contents are not reset.
module wsyn_wave_ram #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] nxt_addr;

    // Neighbour address wraps naturally at ADDR_W bits.
    assign nxt_addr = rd_addr + 1'b1;

    // Write one word and read both neighbours.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_a <= mem[rd_addr];
        rd_b <= mem[nxt_addr];
    end
endmodule

// File: rtl/wsyn_interp.sv
// Two-stage linear blend: stage A forms a*2^F + (b-a)*f at full precision;
// stage B rounds half up to OUT_W bits and saturates.
// Assumes: a and b are signed and registered upstream; OUT_W <= DATA_W;
// f is forced to 0 when byp_in is set.
module wsyn_interp #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned FRAC_W = 8,
    parameter int unsigned OUT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_in,
    input  logic              byp_in,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              vld_out,
    output logic [OUT_W-1:0]  smp_out
);
    localparam int unsigned SUM_W = DATA_W + FRAC_W + 2;
    localparam int unsigned DROP  = DATA_W - OUT_W;
    localparam int unsigned SH    = DROP + FRAC_W;
    localparam logic signed [SUM_W-1:0] HALF = SUM_W'(2 ** (SH - 1));
    localparam logic signed [SUM_W-1:0] OMAX = SUM_W'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [SUM_W-1:0] OMIN = -OMAX - SUM_W'(1);

    logic signed [SUM_W-1:0] a_w, b_w, diff_w, fr_w, prod, sum_n, sum_q;
    logic signed [SUM_W-1:0] rnd, shf;
    logic [OUT_W-1:0]        out_n;
    logic [FRAC_W-1:0]       frac_eff;
    logic                    v_q;

    // Sign-extend both entries and pick the weight.
    always_comb begin
        a_w      = SUM_W'($signed(a));
        b_w      = SUM_W'($signed(b));
        frac_eff = byp_in ? '0 : frac_in;
        fr_w     = SUM_W'($signed({1'b0, frac_eff}));
        diff_w   = b_w - a_w;
        prod     = diff_w * fr_w;
        sum_n    = (a_w <<< FRAC_W) + prod;
    end

    // Stage A register: full-precision blend.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= 1'b0;
            sum_q <= '0;
        end else begin
            v_q   <= vld_in;
            sum_q <= sum_n;
        end
    end

    // Round half up, then clamp to the signed output range.
    always_comb begin
        rnd = sum_q + HALF;
        shf = rnd >>> SH;
        if (shf > OMAX) begin
            out_n = OMAX[OUT_W-1:0];
        end else if (shf < OMIN) begin
            out_n = OMIN[OUT_W-1:0];
        end else begin
            out_n = shf[OUT_W-1:0];
        end
    end

    // Stage B register: output sample, held until the first valid one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_out <= 1'b0;
            smp_out <= '0;
        end else begin
            vld_out <= v_q;
            if (v_q) begin
                smp_out <= out_n;
            end
        end
    end

    // Bounds used by the checks: the output must lie between the rounded
    // neighbours, or on the rounded entry alone in bypass mode.
    logic signed [SUM_W-1:0] mn_w, mx_w, rng_lo, rng_hi, a_lo, a_hi, out_w;
    always_comb begin
        mn_w   = (a_w < b_w) ? a_w : b_w;
        mx_w   = (a_w < b_w) ? b_w : a_w;
        rng_lo = mn_w >>> DROP;
        rng_hi = (mx_w >>> DROP) + SUM_W'(1);
        if (rng_hi > OMAX) rng_hi = OMAX;
        a_lo   = a_w >>> DROP;
        a_hi   = (a_w >>> DROP) + SUM_W'(1);
        if (a_hi > OMAX) a_hi = OMAX;
        out_w  = SUM_W'($signed(smp_out));
    end

    // R4
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_out |-> (out_w >= $past(rng_lo, 2) && out_w <= $past(rng_hi, 2)));

    // R6
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_out && $past(byp_in, 2)) |-> (out_w >= $past(a_lo, 2) && out_w <= $past(a_hi, 2)));
endmodule

// File: rtl/wave_synth.sv
// Interpolating waveform synthesizer top: reset sync, phase register,
// dual-read waveform table, and a two-stage blend. Produces one sample per
// clock with a fixed latency of PIPE_LAT edges from the phase update.
// Assumes: PHASE_W >= ADDR_W + FRAC_W, OUT_W <= DATA_W, FRAC_W >= 1.
module wave_synth #(
    parameter int unsigned PHASE_W = 32,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned FRAC_W  = 8,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned OUT_W   = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tune,
    input  logic               interp_off,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_sample
);
    import wsyn_pkg::*;

    localparam int unsigned FRAC_LSB = PHASE_W - ADDR_W - FRAC_W;

    logic               srst_n;
    logic [PHASE_W-1:0] phase;
    logic               ph_byp, ph_vld;
    logic [ADDR_W-1:0]  rd_addr;
    logic [FRAC_W-1:0]  frac0, frac1;
    logic               byp1, v1;
    logic [DATA_W-1:0]  ent_a, ent_b;

    wsyn_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
        .clk       (clk),
        .rst_n_in  (rst_n),
        .rst_n_sync(srst_n)
    );

    wsyn_phase_acc #(.PHASE_W(PHASE_W)) i_phase (
        .clk   (clk),
        .rst_n (srst_n),
        .tune  (tune),
        .byp_in(interp_off),
        .phase (phase),
        .byp   (ph_byp),
        .vld   (ph_vld)
    );

    assign rd_addr = phase[PHASE_W-1 -: ADDR_W];
    assign frac0   = phase[FRAC_LSB +: FRAC_W];

    wsyn_wave_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ram (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_a   (ent_a),
        .rd_b   (ent_b)
    );

    // Carry weight, mode and valid alongside the table read.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            frac1 <= '0;
            byp1  <= 1'b0;
            v1    <= 1'b0;
        end else begin
            frac1 <= frac0;
            byp1  <= ph_byp;
            v1    <= ph_vld;
        end
    end

    wsyn_interp #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) i_interp (
        .clk    (clk),
        .rst_n  (srst_n),
        .vld_in (v1),
        .byp_in (byp1),
        .frac_in(frac1),
        .a      (ent_a),
        .b      (ent_b),
        .vld_out(out_valid),
        .smp_out(out_sample)
    );

    // R1
    lat_chk: assert property (@(posedge clk) disable iff (!srst_n)
        $rose(out_valid) |-> $past(ph_vld, 3));

    // R1
    stream_chk: assert property (@(posedge clk) disable iff (!srst_n)
        out_valid |=> out_valid);
endmodule

// File: tb/test_wave_synth.sv
// Bench for wave_synth: directed corner cases plus seeded random stimulus,
// compared with a model built from the requirements.
module test_wave_synth;
    localparam int PW = 32;
    localparam int AW = 12;
    localparam int FW = 8;
    localparam int DW = 16;
    localparam int OW = 14;
    localparam int DEPTH = 1 << AW;
    localparam int SH = DW - OW + FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] tune = '0;
    logic          interp_off = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          out_valid;
    logic [OW-1:0] out_sample;

    int checks = 0;
    int fails  = 0;
    int mdl [DEPTH];
    logic [PW-1:0] mdl_ph;
    int    expv [8192];
    string expt [8192];
    int    n_step;

    always #10 clk = ~clk;

    wave_synth #(.PHASE_W(PW), .ADDR_W(AW), .FRAC_W(FW), .DATA_W(DW), .OUT_W(OW)) i_wave_synth (
        .clk(clk), .rst_n(rst_n), .tune(tune), .interp_off(interp_off),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic int exp_sample(logic [PW-1:0] ph, logic byp);
        int k  = int'(ph[PW-1 -: AW]);
        int k1 = (k + 1) % DEPTH;
        longint fr = byp ? 0 : longint'(ph[PW-AW-1 -: FW]);
        longint a = mdl[k];
        longint b = mdl[k1];
        longint s = a * (64'sd1 <<< FW) + (b - a) * fr;
        longint r = (s + (64'sd1 <<< (SH - 1))) >>> SH;
        if (r > 8191) r = 8191;
        if (r < -8192) r = -8192;
        return int'(r);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expd);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expd);
        end
    endtask

    // Write one table word during reset (model follows on the same edge).
    task automatic load_word(input int addr, input int val);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = DW'(val);
        @(posedge clk);
        mdl[addr] = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic enter_reset();
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (4) @(negedge clk);
        // R8: cleared state while reset is held
        chk(out_valid == 1'b0, "R8 valid in reset", int'(out_valid), 0);
        chk(out_sample == '0, "R8 sample in reset", int'($signed(out_sample)), 0);
    endtask

    task automatic leave_reset();
        rst_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        // R8: still idle before the first accumulation
        chk(out_valid == 1'b0, "R8 valid before start", int'(out_valid), 0);
        mdl_ph = '0;
        n_step = 0;
    endtask

    // One clock of running stimulus, followed by the checks due at this point.
    task automatic step(input logic [PW-1:0] tw, input logic byp, input logic we,
                        input int wa, input int wd, input string tag);
        int k;
        tune = tw; interp_off = byp; wr_en = we; wr_addr = AW'(wa); wr_data = DW'(wd);
        @(posedge clk);
        if (we) mdl[wa] = wd;
        mdl_ph = mdl_ph + tw;
        expv[n_step] = exp_sample(mdl_ph, byp);
        expt[n_step] = tag;
        k = n_step;
        n_step++;
        @(negedge clk);
        wr_en = 1'b0;
        // R1: valid from the fourth running step onward
        chk(out_valid == (k >= 3), "R1 valid", int'(out_valid), int'(k >= 3));
        if (k >= 3) begin
            chk(int'($signed(out_sample)) == expv[k-3], expt[k-3],
                int'($signed(out_sample)), expv[k-3]);
        end
    endtask

    initial begin
        logic [PW-1:0] tw;
        void'($urandom(32'd4711));
        enter_reset();
        for (int i = 0; i < DEPTH; i++) begin
            load_word(i, int'($signed(16'($urandom()))));
        end
        load_word(4095, 1000);
        load_word(0, -1000);
        load_word(100, 32767);
        load_word(101, 32767);
        load_word(200, -32768);
        load_word(201, -32768);

        // R3: first phase lands on the last entry, weight one half
        leave_reset();
        step({12'd4095, 8'd128, 12'd0}, 1'b0, 1'b0, 0, 0, "R3 wrap");
        for (int i = 0; i < 5; i++) step('0, 1'b0, 1'b0, 0, 0, "R3 wrap");

        // R5: positive saturation and negative extreme
        enter_reset(); leave_reset();
        step({12'd100, 8'd128, 12'd0}, 1'b0, 1'b0, 0, 0, "R5 saturate");
        step({12'd100, 8'd0, 12'd0}, 1'b0, 1'b0, 0, 0, "R5 negative end");
        for (int i = 0; i < 4; i++) step('0, 1'b0, 1'b0, 0, 0, "R5 hold");

        // R4: fixed tuning word, blended output
        enter_reset(); leave_reset();
        tw = $urandom();
        for (int i = 0; i < 300; i++) step(tw, 1'b0, 1'b0, 0, 0, "R4 blend");

        // R2: tuning word changes every clock
        enter_reset(); leave_reset();
        for (int i = 0; i < 300; i++) step($urandom(), 1'b0, 1'b0, 0, 0, "R2 retune");

        // R6: bypass mode toggling at random
        enter_reset(); leave_reset();
        tw = $urandom();
        for (int i = 0; i < 300; i++) begin
            logic b;
            b = 1'(($urandom() & 1));
            step(tw, b, 1'b0, 0, 0, b ? "R6 bypass" : "R4 blend");
        end

        // R7: write the entry about to be read, while running
        enter_reset(); leave_reset();
        for (int i = 0; i < 600; i++) begin
            logic [PW-1:0] t;
            logic [PW-1:0] nxt;
            t = $urandom();
            nxt = mdl_ph + t;
            step(t, 1'($urandom() & 1), 1'b1, int'(nxt[PW-1 -: AW]),
                 int'($signed(16'($urandom()))), "R7 live write");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule